// File: doc/BRIEF.md
# Block-Chaining DMA Request Sequencer

This block controls the data flow around a 128-bit block cipher core. It sequences up to three level-sensitive DMA request lines through the steps of one chaining mode. The supported modes are electronic codebook, cipher block chaining, output feedback and cipher feedback, and each can run as encryption or decryption. The block watches every bus access to four data ports: a plain load port, a port that XORs and then starts the core, a port that only XORs, and the result port. It counts the bytes moved through the port that the current step expects. It keeps the matching request line high until 16 bytes have passed, and then moves to the next step.

Software first sets the chaining mode, the direction and the enable bit. It then writes a non-zero block count, which starts the sequence. The block issues a one-cycle start pulse to the core and waits for the core's done pulse. Each done pulse lowers the block count by one. After the result of the final block has been read out, the block returns to idle.

Top module: `cms_dma_sequencer`

## Requirements
- R1: `cfg_mode` selects 00 codebook, 01 block chaining, 10 output feedback and 11 cipher feedback. `cfg_op` value 00 means encrypt, and 01 or 11 means decrypt. While `cfg_en` is 0, a block count write is ignored and `dma_req` stays 000.
- R2: In codebook mode, loading a non-zero count raises `dma_req[1]` at once, so the DMA can write the first block to the load port (`acc_port` 00).
- R3: The step's byte tally counts only accesses to the step's port, in the step's direction. Writes go to ports 00, 01 and 10; reads come from port 11. A byte access (`acc_word`=0) adds 1 and a word access adds 2. The request stays high until the tally reaches 16, and then drops on the next cycle. Any other access leaves the request unchanged.
- R4: A write that completes 16 bytes on port 00 or port 01 produces `core_start` for exactly one cycle, on the cycle after that write.
- R5: Codebook mode (both directions): each done pulse raises `dma_req[0]` for 16 bytes read from port 11. After that, `dma_req[1]` is raised for 16 bytes written to port 00. Line 2 is never used.
- R6: Block chaining encrypt: `dma_req[0]` is raised for 16 bytes read from port 11. After that, `dma_req[1]` is raised for 16 bytes written to port 01.
- R7: Block chaining decrypt and cipher feedback decrypt: the request lines run in the order line 0 (write port 10), line 1 (read port 11), line 2 (write port 00).
- R8: Output feedback (both directions): the request lines run in the order line 0 (write port 10), line 1 (read port 11), line 2 (write port 01).
- R9: Cipher feedback encrypt: `dma_req[0]` is raised for port 10 and then `dma_req[1]` for port 11. When the read from port 11 completes and blocks remain, `core_start` is issued.
- R10: In every mode except codebook, no request is raised after the count is loaded. The first block starts when software has written 16 bytes to port 00 or port 01.
- R11: After the done pulse of the last counted block, the sequence stops once the port 11 read completes. All requests are then low, no `core_start` follows, and a new count is accepted.
- R12: Clearing `cfg_en` at any point aborts the sequence, and all requests are low from the next cycle.
- R13: At most one `dma_req` line is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Mode sequencing enable |
| cfg_mode | input | 2 | Chaining mode select |
| cfg_op | input | 2 | Direction: 00 encrypt, x1 decrypt |
| cnt_wr | input | 1 | Block count write strobe |
| cnt_val | input | CNT_W | Block count value |
| acc_valid | input | 1 | Bus access to a data port this cycle |
| acc_write | input | 1 | 1 write, 0 read |
| acc_word | input | 1 | 1 word (2 bytes), 0 byte |
| acc_port | input | 2 | 00 load, 01 XOR and start, 10 XOR only, 11 result |
| core_done | input | 1 | Cipher core finished a block |
| core_start | output | 1 | One-cycle start to the cipher core |
| dma_req | output | 3 | Level-sensitive DMA request lines |

## Verification
A wrong step index or a wrong step table lights the wrong request line on the cycle right after a done pulse or a completed step. The bench checks for this at each transition. A byte tally that is off shows up as a request that drops one access too early or too late. Miscounting blocks shows up at the end of the sequence: either a request stays high after the last result read, or `core_start` fires when it should not. An abort that does not clear the state leaves a request line high one cycle after the enable is cleared.

// File: rtl/cms_pkg.sv
package cms_pkg;

    localparam int BLOCK_BYTES = 16;
    localparam int TALLY_W     = $clog2(BLOCK_BYTES) + 1;
    localparam int NUM_REQ     = 3;

    typedef enum logic [1:0] {
        CH_CODEBOOK = 2'b00,
        CH_CHAIN    = 2'b01,
        CH_OUTFB    = 2'b10,
        CH_CIPHFB   = 2'b11
    } chain_e;

    typedef enum logic [1:0] {
        PT_LOAD   = 2'b00,
        PT_XSTART = 2'b01,
        PT_XONLY  = 2'b10,
        PT_RESULT = 2'b11
    } port_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_FIRSTLD,
        SQ_SWFILL,
        SQ_BUSY,
        SQ_SERVE
    } seq_e;

    typedef struct packed {
        logic  used;
        port_e port;
    } step_t;

    function automatic logic port_is_write(port_e p);
        return p != PT_RESULT;
    endfunction

    function automatic logic port_starts_core(port_e p);
        return (p == PT_LOAD) || (p == PT_XSTART);
    endfunction

    // Step table: trigger line index equals step index
    function automatic step_t step_of(chain_e m, logic dec, logic [1:0] idx);
        step_t s;
        s = '{used: 1'b0, port: PT_LOAD};
        unique case (m)
            CH_CODEBOOK: begin
                if (idx == 2'd0)      s = '{used: 1'b1, port: PT_RESULT};
                else if (idx == 2'd1) s = '{used: 1'b1, port: PT_LOAD};
            end
            CH_CHAIN: begin
                if (!dec) begin
                    if (idx == 2'd0)      s = '{used: 1'b1, port: PT_RESULT};
                    else if (idx == 2'd1) s = '{used: 1'b1, port: PT_XSTART};
                end else begin
                    if (idx == 2'd0)      s = '{used: 1'b1, port: PT_XONLY};
                    else if (idx == 2'd1) s = '{used: 1'b1, port: PT_RESULT};
                    else if (idx == 2'd2) s = '{used: 1'b1, port: PT_LOAD};
                end
            end
            CH_OUTFB: begin
                if (idx == 2'd0)      s = '{used: 1'b1, port: PT_XONLY};
                else if (idx == 2'd1) s = '{used: 1'b1, port: PT_RESULT};
                else if (idx == 2'd2) s = '{used: 1'b1, port: PT_XSTART};
            end
            CH_CIPHFB: begin
                if (idx == 2'd0)      s = '{used: 1'b1, port: PT_XONLY};
                else if (idx == 2'd1) s = '{used: 1'b1, port: PT_RESULT};
                else if (idx == 2'd2 && dec) s = '{used: 1'b1, port: PT_LOAD};
            end
            default: s = '{used: 1'b0, port: PT_LOAD};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/cms_byte_tally.sv
module cms_byte_tally
    import cms_pkg::*;
#(
    parameter int FULL = BLOCK_BYTES,
    localparam int W   = $clog2(FULL) + 1
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic hit,
    input  logic word,
    output logic full
);
    logic [W-1:0] cnt;
    logic [W-1:0] sum;

    assign sum  = cnt + (word ? W'(2) : W'(1));
    assign full = hit && (sum >= W'(FULL));

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt <= '0;
        else if (full)   cnt <= '0;
        else if (hit)    cnt <= sum;
    end

    AST_TALLY_RESTART: assert property (@(posedge clk) disable iff (rst)
        full |=> cnt == '0);                                         // R3
    AST_TALLY_BELOW_FULL: assert property (@(posedge clk) disable iff (rst)
        cnt < W'(FULL));                                             // R3

endmodule

// File: rtl/cms_block_down.sv
module cms_block_down #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else if (dec)  cnt <= cnt - W'(1);
    end

    assign last = (cnt == W'(1));

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        dec |-> cnt != '0);                                          // R11

endmodule

// File: rtl/cms_dma_sequencer.sv
module cms_dma_sequencer
    import cms_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic [1:0]       cfg_mode,
    input  logic [1:0]       cfg_op,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic             acc_word,
    input  logic [1:0]       acc_port,
    input  logic             core_done,
    output logic             core_start,
    output logic [2:0]       dma_req
);
    seq_e       state;
    logic [1:0] step_idx;
    chain_e     mode_q;
    logic       dec_q;
    logic       last_q;
    logic       start_q;

    step_t  cur_step, nxt_step;
    port_e  a_port;
    logic   hit, full, blk_last, load_cnt, blk_dec;

    assign a_port   = port_e'(acc_port);
    assign cur_step = step_of(mode_q, dec_q, step_idx);
    assign nxt_step = step_of(mode_q, dec_q, step_idx + 2'd1);
    assign load_cnt = (state == SQ_IDLE) && cfg_en && cnt_wr && (cnt_val != '0);
    assign blk_dec  = (state == SQ_BUSY) && core_done && cfg_en;

    always_comb begin
        hit = 1'b0;
        if (acc_valid) begin
            unique case (state)
                SQ_FIRSTLD: hit = acc_write && (a_port == PT_LOAD);
                SQ_SWFILL:  hit = acc_write && port_starts_core(a_port);
                SQ_SERVE:   hit = (a_port == cur_step.port) &&
                                  (acc_write == port_is_write(cur_step.port));
                default:    hit = 1'b0;
            endcase
        end
    end

    cms_byte_tally #(.FULL(BLOCK_BYTES)) u_tally (
        .clk  (clk),
        .rst  (rst),
        .clr  (state == SQ_IDLE),
        .hit  (hit),
        .word (acc_word),
        .full (full)
    );

    cms_block_down #(.W(CNT_W)) u_blocks (
        .clk      (clk),
        .rst      (rst),
        .load     (load_cnt),
        .load_val (cnt_val),
        .dec      (blk_dec),
        .last     (blk_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            step_idx <= '0;
            mode_q   <= CH_CODEBOOK;
            dec_q    <= 1'b0;
            last_q   <= 1'b0;
            start_q  <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (!cfg_en) begin
                state <= SQ_IDLE;
            end else begin
                unique case (state)
                    SQ_IDLE: if (load_cnt) begin
                        mode_q   <= chain_e'(cfg_mode);
                        dec_q    <= cfg_op[0];
                        step_idx <= '0;
                        state    <= (chain_e'(cfg_mode) == CH_CODEBOOK) ? SQ_FIRSTLD : SQ_SWFILL;
                    end
                    SQ_FIRSTLD, SQ_SWFILL: if (full) begin
                        start_q <= 1'b1;
                        state   <= SQ_BUSY;
                    end
                    SQ_BUSY: if (core_done) begin
                        last_q   <= blk_last;
                        step_idx <= '0;
                        state    <= SQ_SERVE;
                    end
                    SQ_SERVE: if (full) begin
                        if (cur_step.port == PT_RESULT && last_q) begin
                            state <= SQ_IDLE;
                        end else if (port_starts_core(cur_step.port) || !nxt_step.used) begin
                            start_q <= 1'b1;
                            state   <= SQ_BUSY;
                        end else begin
                            step_idx <= step_idx + 2'd1;
                        end
                    end
                    default: state <= SQ_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        unique case (state)
            SQ_FIRSTLD: dma_req = 3'b010;
            SQ_SERVE:   dma_req = 3'(3'b001 << step_idx);
            default:    dma_req = 3'b000;
        endcase
    end

    assign core_start = start_q;

    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dma_req));                                          // R13
    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> dma_req == 3'b000);                              // R12
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        core_start |=> !core_start);                                 // R4
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (dma_req != 3'b000 && !full && cfg_en) |=> $stable(dma_req)); // R3
    AST_LINE2_LIMITED: assert property (@(posedge clk) disable iff (rst)
        (mode_q == CH_CODEBOOK || (!dec_q && mode_q != CH_OUTFB)) |-> !dma_req[2]); // R5

endmodule

// File: tb/tb_cms_dma_sequencer.sv
module tb_cms_dma_sequencer;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_en;
    logic [1:0] cfg_mode, cfg_op;
    logic       cnt_wr;
    logic [7:0] cnt_val;
    logic       acc_valid, acc_write, acc_word;
    logic [1:0] acc_port;
    logic       core_done;
    logic       core_start;
    logic [2:0] dma_req;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    cms_dma_sequencer #(.CNT_W(8)) dut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_mode(cfg_mode), .cfg_op(cfg_op),
        .cnt_wr(cnt_wr), .cnt_val(cnt_val), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_word(acc_word), .acc_port(acc_port), .core_done(core_done),
        .core_start(core_start), .dma_req(dma_req)
    );

    task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [1:0] port, input logic wr, input logic word, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            acc_valid = 1'b1; acc_port = port; acc_write = wr; acc_word = word;
        end
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic block(input logic [1:0] port, input logic wr, input logic word);
        xfer(port, wr, word, word ? 8 : 16);
    endtask

    task automatic load_count(input logic [7:0] v);
        @(negedge clk); cnt_wr = 1'b1; cnt_val = v;
        @(negedge clk); cnt_wr = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk); core_done = 1'b1;
        @(negedge clk); core_done = 1'b0;
    endtask

    task automatic t_disabled();
        cfg_en = 1'b0; cfg_mode = 2'b00; cfg_op = 2'b00;
        load_count(8'd3);
        repeat (3) @(negedge clk);
        chk({1'b0, dma_req}, 4'b0000, "R1 count ignored while disabled");
    endtask

    task automatic t_codebook();
        cfg_en = 1'b1; cfg_mode = 2'b00; cfg_op = 2'b00;
        load_count(8'd2);
        chk({1'b0, dma_req}, 4'b0010, "R2 first load request");
        xfer(2'b00, 1'b1, 1'b0, 15);
        chk({1'b0, dma_req}, 4'b0010, "R3 request held at 15 bytes");
        xfer(2'b00, 1'b1, 1'b0, 1);
        chk({core_start, dma_req}, 4'b1000, "R4 start after 16th byte");
        @(negedge clk);
        chk({3'b0, core_start}, 4'b0000, "R4 start is one cycle");
        done_pulse();
        chk({1'b0, dma_req}, 4'b0001, "R5 result request after done");
        xfer(2'b11, 1'b1, 1'b1, 3);
        xfer(2'b00, 1'b0, 1'b1, 3);
        xfer(2'b11, 1'b0, 1'b1, 7);
        chk({1'b0, dma_req}, 4'b0001, "R3 wrong accesses ignored, 14 bytes");
        xfer(2'b11, 1'b0, 1'b1, 1);
        chk({1'b0, dma_req}, 4'b0010, "R5 load request after result read");
        block(2'b00, 1'b1, 1'b1);
        chk({core_start, dma_req}, 4'b1000, "R4 word loads start core");
        done_pulse();
        chk({1'b0, dma_req}, 4'b0001, "R5 last block result request");
        block(2'b11, 1'b0, 1'b0);
        chk({core_start, dma_req}, 4'b0000, "R11 idle after last result");
        load_count(8'd1);
        chk({1'b0, dma_req}, 4'b0010, "R11 new count accepted");
        @(negedge clk); cfg_en = 1'b0;
        @(negedge clk);
        chk({1'b0, dma_req}, 4'b0000, "R12 abort clears request");
        cfg_en = 1'b1;
        @(negedge clk);
        chk({1'b0, dma_req}, 4'b0000, "R12 stays idle after re-enable");
    endtask

    // Two blocks through a non-codebook mode; ports of each step given
    task automatic t_chain(input logic [1:0] mode, input logic [1:0] op, input int nsteps,
                           input logic [1:0] p0, input logic [1:0] p1, input logic [1:0] p2,
                           input string tag);
        logic [1:0] ports [3];
        ports[0] = p0; ports[1] = p1; ports[2] = p2;
        cfg_en = 1'b1; cfg_mode = mode; cfg_op = op;
        load_count(8'd2);
        @(negedge clk);
        chk({1'b0, dma_req}, 4'b0000, {"R10 no request before software block ", tag});
        block(2'b01, 1'b1, 1'b1);
        chk({core_start, dma_req}, 4'b1000, {"R10 software block starts core ", tag});
        done_pulse();
        for (int s = 0; s < nsteps; s++) begin
            chk({1'b0, dma_req}, 4'(3'b001 << s), {"step request ", tag});
            block(ports[s], ports[s] != 2'b11, s[0]);
        end
        chk({core_start, dma_req}, 4'b1000, {"sequence end starts core ", tag});
        done_pulse();
        for (int s = 0; s < nsteps; s++) begin
            chk({1'b0, dma_req}, 4'(3'b001 << s), {"R11 last block request ", tag});
            block(ports[s], ports[s] != 2'b11, 1'b0);
            if (ports[s] == 2'b11) break;
        end
        chk({core_start, dma_req}, 4'b0000, {"R11 idle after last result ", tag});
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_en = 1'b0; cfg_mode = 2'b00; cfg_op = 2'b00;
        cnt_wr = 1'b0; cnt_val = '0; acc_valid = 1'b0; acc_write = 1'b0;
        acc_word = 1'b0; acc_port = 2'b00; core_done = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({core_start, dma_req}, 4'b0000, "R1 reset state");
        t_disabled();
        t_codebook();
        t_chain(2'b01, 2'b00, 2, 2'b11, 2'b01, 2'b00, "R6 chain encrypt");
        t_chain(2'b01, 2'b01, 3, 2'b10, 2'b11, 2'b00, "R7 chain decrypt");
        t_chain(2'b11, 2'b11, 3, 2'b10, 2'b11, 2'b00, "R7 R1 cipher feedback decrypt op 11");
        t_chain(2'b10, 2'b00, 3, 2'b10, 2'b11, 2'b01, "R8 output feedback encrypt");
        t_chain(2'b10, 2'b01, 3, 2'b10, 2'b11, 2'b01, "R8 output feedback decrypt");
        t_chain(2'b11, 2'b00, 2, 2'b10, 2'b11, 2'b00, "R9 cipher feedback encrypt");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule